// File: doc/BRIEF.md
# DPLL Lock Qualification Controller

This block runs the calibration sequence for a digital PLL that multiplies a host bus clock. A start pulse latches the measured bus frequency band and loads a frequency window, derived from that band, into the PLL's configuration word with tuning enabled. The block then polls the PLL's lock flag at a fixed interval. When lock appears, the block samples the flag on every clock for a long qualification window. Only a lock that holds for the whole window is accepted. On acceptance, tuning is switched off and success is reported.

A lock that never shows up, or one that drops during qualification, counts as a failed attempt. The window is then rewritten with tuning off and the attempt repeats. After a bounded number of failed attempts, the block reports a fatal failure. The raw lock flag comes from another clock domain, so it passes through a synchronizer before any sampling. Frequency measurement is done elsewhere and arrives as a band code.

Top module: `dpll_lockqual`

## Requirements
- R1: The band code selects the bus frequency: 0 is 33 MHz, 1 is 40 MHz, 2 is 50 MHz and 3 is 66 MHz. The window low value is the floor of MHz×48/66, which gives 24, 29, 36 and 48. The high value is always the low value plus 2.
- R2: The configuration word carries the window low value in bits 7:0, the tuning-enable flag in bit 8, zeros in bits 15:9 and the window high value in bits 31:16.
- R3: When a start pulse arrives while the block is idle, the window for the presented band is loaded with tuning enabled, and both status flags are cleared.
- R4: The lock flag is synchronized through two flops. During polling it is sampled once every POLL_CYCLES clocks. If none of POLL_LIMIT samples shows lock, the attempt fails exactly POLL_LIMIT×POLL_CYCLES clocks after it began.
- R5: Once lock is seen, the synchronized flag is sampled on each of the next STABLE_SAMPLES clocks. Any low sample fails the attempt at once, so a lock pulse shorter than that window is never accepted.
- R6: When the qualification window passes, the tuning-enable flag is cleared and the success flag is set.
- R7: Each failed attempt rewrites the window with tuning disabled and restarts polling. After MAX_ATTEMPTS failed attempts, the fail flag is set and the block returns to idle.
- R8: The success and fail flags are mutually exclusive. Each stays set, whatever the lock flag does, until the next start pulse.
- R9: A start pulse or a band change while a calibration is running has no effect. The window stays as loaded and tuning is not re-enabled.
- R10: After reset, the configuration word is zero and the tuning-enable, success and fail outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that starts a calibration when idle |
| band_i | input | 2 | Measured bus frequency band code |
| lock_raw_i | input | 1 | Asynchronous PLL lock flag |
| win_lo_o | output | 8 | Window low value |
| win_hi_o | output | 8 | Window high value |
| cfg_word_o | output | 32 | Assembled PLL configuration word |
| tune_en_o | output | 1 | Tuning enable |
| cal_ok_o | output | 1 | Sticky calibration success |
| cal_fail_o | output | 1 | Sticky calibration failure |

## Verification
The bench builds the block with POLL_CYCLES=3, POLL_LIMIT=10, STABLE_SAMPLES=8 and MAX_ATTEMPTS=4. With these values, a full exhaustion of all attempts takes 120 clocks, and the timing of both failure and success can be measured exactly against the parameters. A repeating lock pattern that is high for four clocks out of ten is shorter than the qualification window, so it drives every attempt into a stability failure. The small attempt count also makes a retry sequence observable, including a start pulse that lands in the middle of it.

// File: rtl/dlq_pkg.sv
package dlq_pkg;

    localparam int WIN_W    = 8;
    localparam int CFG_W    = 32;
    localparam int HI_LSB   = 16;
    localparam int TUNE_BIT = 8;
    localparam int DPLL_MULT = 48;
    localparam int DPLL_DIV  = 66;
    localparam int WIN_SPAN  = 2;

    typedef enum logic [1:0] {
        BAND_33 = 2'd0,
        BAND_40 = 2'd1,
        BAND_50 = 2'd2,
        BAND_66 = 2'd3
    } band_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_POLL   = 2'd1,
        ST_STABLE = 2'd2
    } seq_e;

    typedef struct packed {
        logic [WIN_W-1:0] hi;
        logic [WIN_W-1:0] lo;
    } win_t;

    function automatic int band_mhz(band_e b);
        case (b)
            BAND_33: return 33;
            BAND_40: return 40;
            BAND_50: return 50;
            default: return 66;
        endcase
    endfunction

    function automatic win_t calc_win(band_e b);
        win_t w;
        int   lo;
        lo   = (band_mhz(b) * DPLL_MULT) / DPLL_DIV;
        w.lo = WIN_W'(lo);
        w.hi = WIN_W'(lo + WIN_SPAN);
        return w;
    endfunction

    function automatic logic [CFG_W-1:0] pack_cfg(win_t w, logic tune);
        logic [CFG_W-1:0] c;
        c = '0;
        c[WIN_W-1:0]             = w.lo;
        c[TUNE_BIT]              = tune;
        c[HI_LSB +: WIN_W]       = w.hi;
        return c;
    endfunction

endpackage

// File: rtl/dlq_sync.sv
module dlq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain_q[g] <= 1'b0;
                    else       chain_q[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain_q[g] <= 1'b0;
                    else       chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dlq_tick.sv
module dlq_tick #(
    parameter int PERIOD = 5000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = $clog2(PERIOD + 1);
    logic [CW-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == CW'(PERIOD - 1));

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i || tick_o) cnt_q <= '0;
        else                           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/dlq_window.sv
module dlq_window
    import dlq_pkg::*;
(
    input  band_e band_i,
    output win_t  win_o
);
    always_comb win_o = calc_win(band_i);
endmodule

// File: rtl/dpll_lockqual.sv
module dpll_lockqual
    import dlq_pkg::*;
#(
    parameter int POLL_CYCLES    = 5000,
    parameter int POLL_LIMIT     = 20480,
    parameter int STABLE_SAMPLES = 4096,
    parameter int MAX_ATTEMPTS   = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic [1:0]       band_i,
    input  logic             lock_raw_i,
    output logic [WIN_W-1:0] win_lo_o,
    output logic [WIN_W-1:0] win_hi_o,
    output logic [CFG_W-1:0] cfg_word_o,
    output logic             tune_en_o,
    output logic             cal_ok_o,
    output logic             cal_fail_o
);
    localparam int PW = $clog2(POLL_LIMIT + 1);
    localparam int SW = $clog2(STABLE_SAMPLES + 1);
    localparam int AW = $clog2(MAX_ATTEMPTS + 1);

    seq_e          st;
    logic [PW-1:0] poll_cnt;
    logic [SW-1:0] stab_cnt;
    logic [AW-1:0] attempt;
    win_t          win_q;
    win_t          win_c;
    logic          tune_q;
    logic          ok_q;
    logic          fail_q;
    logic          lock_s;
    logic          tick;
    logic          att_fail;

    dlq_sync #(.STAGES(2)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (lock_raw_i),
        .q_o   (lock_s)
    );

    dlq_tick #(.PERIOD(POLL_CYCLES)) u_tick (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .run_i  (st == ST_POLL),
        .tick_o (tick)
    );

    dlq_window u_win (
        .band_i (band_e'(band_i)),
        .win_o  (win_c)
    );

    always_comb begin
        att_fail = 1'b0;
        if (st == ST_POLL && tick && !lock_s && poll_cnt == PW'(POLL_LIMIT - 1))
            att_fail = 1'b1;
        if (st == ST_STABLE && !lock_s)
            att_fail = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st       <= ST_IDLE;
            poll_cnt <= '0;
            stab_cnt <= '0;
            attempt  <= '0;
            win_q    <= '0;
            tune_q   <= 1'b0;
            ok_q     <= 1'b0;
            fail_q   <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start_i) begin
                        win_q    <= win_c;
                        tune_q   <= 1'b1;
                        ok_q     <= 1'b0;
                        fail_q   <= 1'b0;
                        attempt  <= '0;
                        poll_cnt <= '0;
                        st       <= ST_POLL;
                    end
                end
                ST_POLL: begin
                    if (tick) begin
                        if (lock_s) begin
                            stab_cnt <= '0;
                            st       <= ST_STABLE;
                        end else begin
                            poll_cnt <= poll_cnt + 1'b1;
                        end
                    end
                end
                ST_STABLE: begin
                    if (lock_s) begin
                        if (stab_cnt == SW'(STABLE_SAMPLES - 1)) begin
                            tune_q <= 1'b0;
                            ok_q   <= 1'b1;
                            st     <= ST_IDLE;
                        end else begin
                            stab_cnt <= stab_cnt + 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase

            if (att_fail) begin
                tune_q <= 1'b0;
                if (attempt == AW'(MAX_ATTEMPTS - 1)) begin
                    fail_q <= 1'b1;
                    st     <= ST_IDLE;
                end else begin
                    attempt  <= attempt + 1'b1;
                    poll_cnt <= '0;
                    st       <= ST_POLL;
                end
            end
        end
    end

    assign win_lo_o   = win_q.lo;
    assign win_hi_o   = win_q.hi;
    assign cfg_word_o = pack_cfg(win_q, tune_q);
    assign tune_en_o  = tune_q;
    assign cal_ok_o   = ok_q;
    assign cal_fail_o = fail_q;
endmodule

// File: rtl/dlq_checker.sv
module dlq_checker
    import dlq_pkg::*;
#(
    parameter int MAX_ATTEMPTS = 8,
    parameter int AW = 4
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             start_i,
    input logic             tune_en_o,
    input logic             cal_ok_o,
    input logic             cal_fail_o,
    input logic [WIN_W-1:0] win_lo_o,
    input seq_e             st,
    input logic [AW-1:0]    attempt,
    input logic             lock_s
);
    p_excl_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !(cal_ok_o && cal_fail_o));

    p_ok_sticky_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (cal_ok_o && !start_i) |=> cal_ok_o);

    p_fail_sticky_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (cal_fail_o && !start_i) |=> cal_fail_o);

    p_tune_from_start_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(tune_en_o) |-> $past(start_i));

    p_ok_untuned_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(cal_ok_o) |-> !tune_en_o);

    p_fail_bound_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(cal_fail_o) |-> (attempt == AW'(MAX_ATTEMPTS - 1)));

    p_break_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (st == ST_STABLE && !lock_s) |=> (st != ST_STABLE && !cal_ok_o));

    p_win_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (st != ST_IDLE) |=> $stable(win_lo_o));
endmodule

bind dpll_lockqual dlq_checker #(
    .MAX_ATTEMPTS (MAX_ATTEMPTS),
    .AW           (AW)
) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .start_i    (start_i),
    .tune_en_o  (tune_en_o),
    .cal_ok_o   (cal_ok_o),
    .cal_fail_o (cal_fail_o),
    .win_lo_o   (win_lo_o),
    .st         (st),
    .attempt    (attempt),
    .lock_s     (lock_s)
);

// File: tb/dpll_lockqual_tb_top.sv
module dpll_lockqual_tb_top;
    localparam int PC = 3;
    localparam int PL = 10;
    localparam int SS = 8;
    localparam int MA = 4;
    localparam int NV = 6;

    // fields: band[12:11], mode[10:9], exp_ok[8], exp_lo[7:0]
    // mode 0 never locks, 1 steady lock, 2 short repeating pulses, 3 pulses then steady
    localparam logic [12:0] VEC [NV] = '{
        {2'd0, 2'd1, 1'b1, 8'd24},
        {2'd1, 2'd0, 1'b0, 8'd29},
        {2'd2, 2'd2, 1'b0, 8'd36},
        {2'd3, 2'd1, 1'b1, 8'd48},
        {2'd1, 2'd3, 1'b1, 8'd29},
        {2'd2, 2'd1, 1'b1, 8'd36}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  band = 2'd0;
    logic        lock = 1'b0;
    logic [7:0]  win_lo, win_hi;
    logic [31:0] cfg;
    logic        tune, ok, fail;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int lock_mode = 0;
    int pat = 0;

    always #4 clk = ~clk;

    dpll_lockqual #(
        .POLL_CYCLES    (PC),
        .POLL_LIMIT     (PL),
        .STABLE_SAMPLES (SS),
        .MAX_ATTEMPTS   (MA)
    ) dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .start_i    (start),
        .band_i     (band),
        .lock_raw_i (lock),
        .win_lo_o   (win_lo),
        .win_hi_o   (win_hi),
        .cfg_word_o (cfg),
        .tune_en_o  (tune),
        .cal_ok_o   (ok),
        .cal_fail_o (fail)
    );

    always @(negedge clk) begin
        pat <= (pat == 9) ? 0 : pat + 1;
        case (lock_mode)
            1:       lock <= 1'b1;
            2:       lock <= (pat < 4);
            default: lock <= 1'b0;
        endcase
    end

    task automatic chk(input bit cond, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_cfg(logic [7:0] lo, logic t);
        return {8'h00, lo + 8'd2, 7'h00, t, lo};
    endfunction

    task automatic pulse_start(input logic [1:0] b);
        band  = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected done", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(cfg == 32'h0, "R10 cfg", cfg, 32'h0);
        chk(!tune && !ok && !fail, "R10 flags", {tune, ok, fail}, 3'b000);

        for (int v = 0; v < NV; v++) begin
            logic [1:0] vb;
            int         vm;
            logic       vok;
            logic [7:0] vlo;
            int         n;
            vb  = VEC[v][12:11];
            vm  = int'(VEC[v][10:9]);
            vok = VEC[v][8];
            vlo = VEC[v][7:0];

            lock_mode = (vm == 3) ? 2 : vm;
            repeat (12) @(negedge clk);
            pulse_start(vb);
            // R1 R2 R3 window loaded with tuning on, status cleared
            chk(win_lo == vlo, "R1 win_lo", win_lo, vlo);
            chk(win_hi == vlo + 8'd2, "R1 win_hi", win_hi, vlo + 8'd2);
            chk(cfg == exp_cfg(vlo, 1'b1), "R2 cfg tuned", cfg, exp_cfg(vlo, 1'b1));
            chk(tune && !ok && !fail, "R3 start", {tune, ok, fail}, 3'b100);

            n = 0;
            if (vm == 3) begin
                while (tune && n < 1000) begin @(negedge clk); n++; end
                chk(!tune && !ok && !fail, "R7 retry untuned", {tune, ok, fail}, 3'b000);
                // R9 start and band change mid-run ignored
                pulse_start(~vb);
                chk(!tune, "R9 start ignored tune", tune, 0);
                chk(win_lo == vlo, "R9 window held", win_lo, vlo);
                lock_mode = 1;
                n = 0;
            end

            while (!(ok || fail) && n < 2000) begin @(negedge clk); n++; end
            chk(ok == vok && fail == !vok, "R6 R7 outcome", {ok, fail}, {vok, !vok});
            chk(cfg == exp_cfg(vlo, 1'b0), "R6 cfg untuned", cfg, exp_cfg(vlo, 1'b0));

            if (vm == 1)
                chk(n >= SS + PC && n <= SS + PC + 2, "R5 qual length", n, SS + PC);
            if (vm == 0)
                chk(n >= MA * PL * PC && n <= MA * PL * PC + 2, "R4 R7 exhaust time",
                    n, MA * PL * PC);

            // R8 stickiness while lock changes
            lock_mode = vok ? 0 : 1;
            repeat (20) @(negedge clk);
            chk(ok == vok && fail == !vok, "R8 sticky", {ok, fail}, {vok, !vok});
        end

        // R10 reset mid-run
        lock_mode = 0;
        repeat (5) @(negedge clk);
        pulse_start(2'd3);
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(cfg == 32'h0 && !tune && !ok && !fail, "R10 mid-run reset",
            {cfg[15:0], tune, ok, fail}, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule